// File: doc/BRIEF.md
# Performance Monitor User Access Gate

This block guards a small performance-monitor register file against user-mode accesses. The file holds eight 32-bit words: two control words (CTL0 and CTL2) and six event counters (PMC1 to PMC6). A two-bit permission code, PMCC, kept inside CTL0 sets what a user-mode program may do. Depending on that code, the direction of the access and the register touched, a user request is either served or refused with an exception code. Served reads of the control words show only a small set of user-visible bits. Served writes to them change only those bits and keep the rest.

Supervisor-mode requests bypass every check. They read and write all 32 bits of any register. They are the only way to set PMCC, because that field lies outside the user-writable bits of CTL0. Responses come back registered one cycle after the request. Writes update the file on the edge that accepts the request.

Top module: `pmu_user_gate`

## Requirements
- R1: After reset every register is zero (so PMCC is 2'b00), and rsp_valid, rsp_rdata, exc_valid and exc_code are all zero.
- R2: A user read of CTL0 (sel 0), CTL2 (sel 1) or PMC1 to PMC4 (sel 2 to 5) is served for every PMCC except 2'b01. With PMCC 2'b01 it is refused with exc_code 0 (facility unavailable).
- R3: A user write to sel 0 to 5 is served only with PMCC 2'b10 or 2'b11. With PMCC 2'b00 it is refused with exc_code 1 (emulation assist). With PMCC 2'b01 it is refused with exc_code 0.
- R4: With PMCC 2'b11, every user read or write of PMC5 (sel 6) or PMC6 (sel 7) is refused with exc_code 0. With any other PMCC these two counters follow R2 and R3.
- R5: A served user read of CTL0 returns only bits 31, 26 and 7. Every other bit reads as zero.
- R6: A served user read of CTL2 returns only bits 30, 21, 12 and 3. Every other bit reads as zero.
- R7: A served user write to CTL0 or CTL2 stores (old & ~mask) | (wdata & mask), using the mask of R5 or R6. All other bits keep their old value, including PMCC.
- R8: Served user reads and writes of PMC1 to PMC6 use all 32 bits with no masking.
- R9: A refused request leaves the register file unchanged. Its response carries rsp_rdata zero and a one-cycle exc_valid pulse.
- R10: Each request yields exactly one rsp_valid pulse one cycle later, with the read data registered. A write is visible to a request issued in the very next cycle.
- R11: A supervisor request (req_user low) never raises an exception. It reads and writes all 32 bits of any register, including PMCC at CTL0 bits 19:18 (PMCC[1] is bit 19).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| req_sel | input | 3 | Register select: 0 CTL0, 1 CTL2, 2..7 PMC1..PMC6 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data; zero for writes and refused requests |
| exc_valid | output | 1 | Refusal pulse |
| exc_code | output | 1 | 0 facility unavailable, 1 emulation assist |

## Verification
The hardest case to reach is a user request that meets a PMCC value which only a supervisor write can set. The most demanding instance is PMCC 2'b11, where PMC5 and PMC6 are refused while PMC1 to PMC4 stay open. The stimulus uses supervisor writes to walk PMCC through all four codes. It runs the same mix of user reads and writes at each step, and gives the control words dense bit patterns so that masked views and partial merges show. Supervisor read-backs after refused or partial writes expose the stored state at the ports. Back-to-back requests cover the case where a read follows a write in the next cycle.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;

  typedef enum logic [2:0] {
    SEL_CTL0 = 3'd0,
    SEL_CTL2 = 3'd1,
    SEL_PMC1 = 3'd2,
    SEL_PMC2 = 3'd3,
    SEL_PMC3 = 3'd4,
    SEL_PMC4 = 3'd5,
    SEL_PMC5 = 3'd6,
    SEL_PMC6 = 3'd7
  } pmu_sel_e;

  typedef enum logic {
    EXC_FAC_UNAVAIL = 1'b0,
    EXC_EMUL_ASSIST = 1'b1
  } exc_code_e;

  typedef struct packed {
    logic      grant;
    logic      refuse;
    exc_code_e code;
  } verdict_t;

endpackage

// File: rtl/pmu_access_policy.sv
module pmu_access_policy
  import pmu_gate_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             user,
  input  logic             write,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       pmcc,
  output verdict_t         verdict
);

  logic outer_ctr;

  assign outer_ctr = (sel == SEL_PMC5) || (sel == SEL_PMC6);

  always_comb begin
    verdict = '{grant: 1'b1, refuse: 1'b0, code: EXC_FAC_UNAVAIL};
    if (user) begin
      if (outer_ctr && pmcc == 2'b11) begin
        verdict.refuse = 1'b1;
      end else if (pmcc == 2'b01) begin
        verdict.refuse = 1'b1;
      end else if (write && pmcc == 2'b00) begin
        verdict.refuse = 1'b1;
        verdict.code   = EXC_EMUL_ASSIST;
      end
      verdict.grant = !verdict.refuse;
    end
  end

endmodule

// File: rtl/pmu_mask_unit.sv
module pmu_mask_unit
  import pmu_gate_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              SEL_W     = 3,
  parameter logic [DATA_W-1:0] CTL0_MASK = 32'h8400_0080,
  parameter logic [DATA_W-1:0] CTL2_MASK = 32'h4020_1008
) (
  input  logic              user,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] read_view,
  output logic [DATA_W-1:0] write_merge
);

  logic [DATA_W-1:0] eff_mask;

  always_comb begin
    eff_mask = '1;
    if (user) begin
      if (sel == SEL_CTL0)      eff_mask = CTL0_MASK;
      else if (sel == SEL_CTL2) eff_mask = CTL2_MASK;
    end
  end

  assign read_view   = old_word & eff_mask;
  assign write_merge = (old_word & ~eff_mask) | (wdata & eff_mask);

endmodule

// File: rtl/pmu_regfile.sv
module pmu_regfile #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ctl0_word
);

  localparam int DEPTH = 2 ** SEL_W;

  logic [DATA_W-1:0] word_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                 word_q[gi] <= '0;
      else if (we && addr == SEL_W'(gi))       word_q[gi] <= wdata;
    end
  end

  assign rdata     = word_q[addr];
  assign ctl0_word = word_q[0];

endmodule

// File: rtl/pmu_user_gate.sv
module pmu_user_gate
  import pmu_gate_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                SEL_W     = 3,
  parameter int                PMCC_LSB  = 18,
  parameter logic [DATA_W-1:0] CTL0_MASK = 32'h8400_0080,
  parameter logic [DATA_W-1:0] CTL2_MASK = 32'h4020_1008
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              exc_valid,
  output logic              exc_code
);

  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] ctl0_word;
  logic [DATA_W-1:0] read_view;
  logic [DATA_W-1:0] write_merge;
  logic [1:0]        pmcc;
  verdict_t          verdict;
  logic              wr_en;

  assign pmcc  = ctl0_word[PMCC_LSB +: 2];
  assign wr_en = req_valid && req_write && verdict.grant;

  pmu_access_policy #(.SEL_W(SEL_W)) u_policy (
    .user    (req_user),
    .write   (req_write),
    .sel     (req_sel),
    .pmcc    (pmcc),
    .verdict (verdict)
  );

  pmu_mask_unit #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .CTL0_MASK(CTL0_MASK), .CTL2_MASK(CTL2_MASK)
  ) u_mask (
    .user        (req_user),
    .sel         (req_sel),
    .old_word    (old_word),
    .wdata       (req_wdata),
    .read_view   (read_view),
    .write_merge (write_merge)
  );

  pmu_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (wr_en),
    .addr      (req_sel),
    .wdata     (write_merge),
    .rdata     (old_word),
    .ctl0_word (ctl0_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      exc_valid <= 1'b0;
      exc_code  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      exc_valid <= req_valid && verdict.refuse;
      exc_code  <= (req_valid && verdict.refuse) ? verdict.code : 1'b0;
      rsp_rdata <= (req_valid && !req_write && verdict.grant) ? read_view : '0;
    end
  end

  AST_REFUSE_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (rsp_rdata == '0 && rsp_valid)); // R9
  AST_REFUSE_KEEPS_PMCC: assert property (@(posedge clk) disable iff (rst)
    (req_valid && verdict.refuse) |=> (pmcc == $past(pmcc))); // R9
  AST_SUPERVISOR_NO_EXC: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_user) |=> !exc_valid); // R11
  AST_EMUL_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && exc_code == 1'b1 && exc_valid) |-> 1'b1 ##0 $past(req_write && pmcc == 2'b00)); // R3
  AST_OUTER_CTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && req_sel >= SEL_W'(SEL_PMC5) && pmcc == 2'b11)
      |=> (exc_valid && exc_code == 1'b0)); // R4
  AST_CTL0_VIEW: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && !req_write && req_sel == '0)
      |=> ((rsp_rdata & ~CTL0_MASK) == '0)); // R5
  AST_CTL2_VIEW: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user && !req_write && req_sel == SEL_W'(1))
      |=> ((rsp_rdata & ~CTL2_MASK) == '0)); // R6

endmodule

// File: tb/pmu_user_gate_bench.sv
`timescale 1ns/1ps
module pmu_user_gate_bench;

  localparam logic [31:0] M0 = 32'h8400_0080;
  localparam logic [31:0] M2 = 32'h4020_1008;

  typedef struct {
    logic [31:0] rdata;
    logic        exc;
    logic        code;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_user  = 1'b0;
  logic [2:0]  req_sel   = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        exc_valid;
  logic        exc_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t        sb[$];
  logic [31:0] mdl [8];

  always #10 clk = ~clk;

  pmu_user_gate u_pmu_user_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_user(req_user), .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .exc_valid(exc_valid), .exc_code(exc_code)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: reference model of R2..R11, pushes expected response
  task automatic do_req(input logic u, input logic w, input logic [2:0] s,
                        input logic [31:0] d, input string tag);
    logic [1:0]  pm;
    logic [31:0] mask;
    exp_t        e;
    pm   = mdl[0][19:18];
    mask = 32'hFFFF_FFFF;
    if (u && s == 3'd0) mask = M0;
    if (u && s == 3'd1) mask = M2;
    e.tag = tag; e.exc = 1'b0; e.code = 1'b0; e.rdata = '0;
    if (u && s >= 3'd6 && pm == 2'b11)  e.exc = 1'b1;
    else if (u && pm == 2'b01)          e.exc = 1'b1;
    else if (u && w && pm == 2'b00) begin e.exc = 1'b1; e.code = 1'b1; end
    if (!e.exc) begin
      if (w) mdl[s] = (mdl[s] & ~mask) | (d & mask);
      else   e.rdata = mdl[s] & mask;
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_user = u; req_sel = s; req_wdata = d;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
    end
  endtask

  // Monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected response actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " rdata"}, rsp_rdata, e.rdata);
          check({e.tag, " exc_valid"}, {31'd0, exc_valid}, {31'd0, e.exc});
          check({e.tag, " exc_code"}, {31'd0, exc_code}, {31'd0, e.code});
        end
      end else if (exc_valid) begin
        checks++; errors++;
        $display("FAIL R9 exc_valid without response actual=1 expected=0");
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 rsp_rdata", rsp_rdata, 32'd0);
    check("R1 exc_valid", {31'd0, exc_valid}, 32'd0);
    check("R1 exc_code",  {31'd0, exc_code}, 32'd0);
    do_req(0, 0, 3'd0, 0, "R1 sup read CTL0 zero");
    do_req(0, 0, 3'd7, 0, "R1 sup read PMC6 zero");
    // PMCC = 00
    do_req(1, 0, 3'd0, 0, "R2 pmcc00 user read CTL0");
    do_req(1, 1, 3'd2, 32'hDEAD_BEEF, "R3 pmcc00 user write PMC1 refused");
    do_req(0, 0, 3'd2, 0, "R9 PMC1 unchanged after refusal");
    do_req(1, 1, 3'd0, 32'hFFFF_FFFF, "R3 pmcc00 user write CTL0 refused");
    do_req(1, 0, 3'd6, 0, "R4 pmcc00 user read PMC5");
    // supervisor loads counters and control words, PMCC = 01
    for (int i = 2; i < 8; i++) do_req(0, 1, 3'(i), 32'h1111_1111 * i, "R11 sup write PMC");
    do_req(0, 1, 3'd1, 32'hFFFF_FFFF, "R11 sup write CTL2");
    do_req(0, 1, 3'd0, 32'hFFF7_FFFF, "R11 sup write CTL0 pmcc01");
    do_req(0, 0, 3'd0, 0, "R11 sup read CTL0 full");
    do_req(1, 0, 3'd0, 0, "R2 pmcc01 user read CTL0 refused");
    do_req(1, 0, 3'd3, 0, "R2 pmcc01 user read PMC2 refused");
    do_req(1, 1, 3'd1, 0, "R3 pmcc01 user write CTL2 refused");
    do_req(1, 0, 3'd7, 0, "R4 pmcc01 user read PMC6 refused");
    do_req(0, 0, 3'd1, 0, "R9 CTL2 unchanged");
    idle(2);
    // PMCC = 10
    do_req(0, 1, 3'd0, 32'h5B6A_A5C3, "R11 sup write CTL0 pmcc10");
    do_req(1, 0, 3'd0, 0, "R5 user read CTL0 masked");
    do_req(1, 1, 3'd0, 32'h0000_0000, "R7 user write CTL0 clears masked");
    do_req(0, 0, 3'd0, 0, "R7 CTL0 unmasked bits kept");
    do_req(1, 1, 3'd0, 32'hFFFF_FFFF, "R7 user write CTL0 sets masked");
    do_req(0, 0, 3'd0, 0, "R7 CTL0 after set");
    do_req(1, 0, 3'd1, 0, "R6 user read CTL2 masked");
    do_req(1, 1, 3'd1, 32'h0000_0000, "R7 user write CTL2");
    do_req(0, 0, 3'd1, 0, "R7 CTL2 unmasked bits kept");
    do_req(1, 1, 3'd4, 32'hA5A5_5A5A, "R8 user write PMC3");
    do_req(1, 0, 3'd4, 0, "R10 R8 user read PMC3 next cycle");
    do_req(1, 1, 3'd7, 32'hC0FF_EE01, "R4 pmcc10 user write PMC6");
    do_req(1, 0, 3'd7, 0, "R8 user read PMC6 full width");
    // PMCC = 11
    do_req(0, 1, 3'd0, 32'h000C_0000, "R11 sup write CTL0 pmcc11");
    do_req(1, 0, 3'd6, 0, "R4 pmcc11 user read PMC5 refused");
    do_req(1, 1, 3'd7, 32'h1234_5678, "R4 pmcc11 user write PMC6 refused");
    do_req(0, 0, 3'd7, 0, "R9 PMC6 unchanged");
    do_req(1, 0, 3'd3, 0, "R2 pmcc11 user read PMC2");
    do_req(1, 1, 3'd5, 32'h0BAD_F00D, "R3 pmcc11 user write PMC4");
    do_req(1, 0, 3'd5, 0, "R8 user read PMC4");
    do_req(1, 1, 3'd0, 32'h0000_0000, "R7 pmcc11 user write CTL0 keeps PMCC");
    do_req(1, 0, 3'd6, 0, "R4 PMCC still 11 after user write");
    idle(4);
    check("R10 all responses seen", sb.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule